// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This unit computes the byte-enable pattern that a partial store needs at the ragged ends of a buffer that is processed eight bytes at a time. Software hands it the address of the current 8-byte block and the address of the last byte to be written, together with an operation code. The code selects the element granularity (bytes, halfwords or words), the lane order (big- or little-endian) and whether the integer condition codes are to be updated. The result is a lane mask with one bit per element of the 8-byte block. The unit also produces the condition codes of the subtraction first address minus second address, in both 32-bit and 64-bit form.

The left mask enables the lanes from the first address onward. The right mask enables the lanes up to and including the second address. The two are combined only when both addresses fall in the same aligned 8-byte block. In 32-bit addressing mode the addresses are cut to their low 32 bits for the mask work, but the condition codes always come from the full 64-bit values. Results are registered and appear one cycle after a start strobe.

Top module: `edge_mask_unit`

## Requirements
- R1: After reset, `done_o`, `bad_op_o`, `cc_we_o`, `lane_mask_o` and both flag outputs are zero. Each cycle with `start_i` high produces exactly one cycle of `done_o` on the next cycle, and `done_o` never rises without a start in the previous cycle.
- R2: The operation code is decoded as follows. Bits [3:2] select the element size (0 = byte, 1 = halfword, 2 = word). Bit 1 selects little-endian lane order. Bit 0 set means no flag update. `cc_we_o` is high in the result cycle exactly for legal codes whose bit 0 is clear.
- R3: Byte size, big-endian: with offset o1 = first address [2:0], the left mask is 0xFF shifted right by o1. With o2 = second address [2:0], the right mask is 0xFF shifted left by 7−o2 and kept to 8 bits.
- R4: Halfword size uses index address[2:1] and 4-bit masks. Big-endian gives left masks F,7,3,1 and right masks 8,C,E,F. Little-endian gives left masks F,E,C,8 and right masks 1,3,7,F.
- R5: Word size uses index address[2] and 2-bit masks. Big-endian gives left masks 3,1 and right masks 2,3. Little-endian gives left masks 3,2 and right masks 1,3.
- R6: Byte size, little-endian: both masks are the bitwise mirror of the big-endian masks of R3.
- R7: If the two addresses agree in every bit above bit 2, `lane_mask_o` is left AND right. Otherwise it is the left mask alone.
- R8: With `addr32_i` high, both addresses are reduced to their low 32 bits before the mask and block comparison of R3–R7.
- R9: For flag-setting codes, `cc32_o` and `cc64_o` take {N,Z,V,C} (bit 3 = N … bit 0 = C) of first minus second address, computed on the untruncated 64-bit values. C means a borrow occurred.
- R10: For no-flag codes, `cc32_o` and `cc64_o` keep their previous values.
- R11: Codes above 0x00B raise `bad_op_o` in the result cycle. They leave `lane_mask_o`, `cc32_o` and `cc64_o` unchanged, and `cc_we_o` stays low.
- R12: Mask bits above the lane count of the selected size (bits 7:4 for halfwords, bits 7:2 for words) are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch one mask computation this cycle |
| opcode_i | input | 9 | Operation code selecting size, lane order and flag update |
| addr_a_i | input | 64 | First address (start of the block) |
| addr_b_i | input | 64 | Second address (last byte to cover) |
| addr32_i | input | 1 | 32-bit addressing mode for the mask computation |
| done_o | output | 1 | Result registers were loaded by the previous start |
| bad_op_o | output | 1 | The previous start carried an illegal code |
| cc_we_o | output | 1 | Flag outputs were updated by the previous start |
| lane_mask_o | output | 8 | Lane enable mask, lane 0 in bit 0 |
| cc32_o | output | 4 | {N,Z,V,C} of the 32-bit difference |
| cc64_o | output | 4 | {N,Z,V,C} of the 64-bit difference |

## Verification
The bench builds the unit with its default 64-bit addresses and 32-bit narrow width. This makes truncation observable: the bench uses address pairs that differ only above bit 31. These pairs share a block in narrow mode and fall in different blocks in full mode. The same pairs yield a zero 32-bit difference against a nonzero 64-bit one. Sweeping all eight offsets of both addresses over every legal code, and following with random mixes that include illegal codes and back-to-back starts, brings every table entry and each held-value path within reach.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;

    localparam int OPC_W     = 9;
    localparam int BLK_BYTES = 8;
    localparam int OFF_W     = $clog2(BLK_BYTES);
    localparam int MASK_W    = BLK_BYTES;
    localparam int N_SIZES   = OFF_W;
    localparam logic [OPC_W-1:0] LAST_CODE = OPC_W'(11);

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_NONE = 2'd3
    } esize_e;

    typedef struct packed {
        logic   legal;
        esize_e size;
        logic   little;
        logic   no_flags;
    } op_dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccode_t;

    function automatic op_dec_t decode_op(input logic [OPC_W-1:0] op);
        op_dec_t d;
        d.legal    = (op <= LAST_CODE);
        d.size     = esize_e'(op[3:2]);
        d.little   = op[1];
        d.no_flags = op[0];
        return d;
    endfunction

endpackage

// File: rtl/edge_lane_masks.sv
module edge_lane_masks
    import edge_mask_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [OFF_W-1:0]  off_a,
    input  logic [OFF_W-1:0]  off_b,
    input  logic              little,
    output logic [MASK_W-1:0] left_m,
    output logic [MASK_W-1:0] right_m
);
    localparam int SHIFT = $clog2(MASK_W / LANES);
    localparam int IDX_W = OFF_W - SHIFT;
    localparam logic [LANES-1:0] FULL = '1;
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(LANES - 1);

    logic [IDX_W-1:0] idx_a, idx_b;
    logic [LANES-1:0] l_be, r_be, l_mir, r_mir, l_sel, r_sel;

    assign idx_a = off_a[OFF_W-1:SHIFT];
    assign idx_b = off_b[OFF_W-1:SHIFT];

    // big-endian: lane of lowest address sits in the top bit
    assign l_be = FULL >> idx_a;
    assign r_be = FULL << (TOP - idx_b);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            l_mir[i] = l_be[LANES-1-i];
            r_mir[i] = r_be[LANES-1-i];
        end
    end

    assign l_sel   = little ? l_mir : l_be;
    assign r_sel   = little ? r_mir : r_be;
    assign left_m  = MASK_W'(l_sel);
    assign right_m = MASK_W'(r_sel);

endmodule

// File: rtl/edge_cc_calc.sv
module edge_cc_calc
    import edge_mask_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output ccode_t       cc
);
    logic [W:0] ext;

    always_comb begin
        ext  = {1'b0, a} - {1'b0, b};
        cc.n = ext[W-1];
        cc.z = (ext[W-1:0] == '0);
        cc.v = (a[W-1] ^ b[W-1]) & (ext[W-1] ^ a[W-1]);
        cc.c = ext[W];
    end

endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
    import edge_mask_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [ADDR_W-1:0] addr_a_i,
    input  logic [ADDR_W-1:0] addr_b_i,
    input  logic              addr32_i,
    output logic              done_o,
    output logic              bad_op_o,
    output logic              cc_we_o,
    output logic [MASK_W-1:0] lane_mask_o,
    output logic [3:0]        cc32_o,
    output logic [3:0]        cc64_o
);
    localparam int HI_W = ADDR_W - NARROW_W;

    op_dec_t           dec;
    logic [ADDR_W-1:0] eff_a, eff_b;
    logic              same_blk;
    logic [MASK_W-1:0] left_arr  [N_SIZES];
    logic [MASK_W-1:0] right_arr [N_SIZES];
    logic [MASK_W-1:0] left_sel, right_sel, mask_n;
    ccode_t            cc_lo_n, cc_hi_n;

    logic              done_q, bad_q, we_q;
    logic [MASK_W-1:0] mask_q;
    ccode_t            cc_lo_q, cc_hi_q;

    assign dec = decode_op(opcode_i);

    // narrow mode clears the upper address half for the mask path only
    assign eff_a = addr32_i ? {{HI_W{1'b0}}, addr_a_i[NARROW_W-1:0]} : addr_a_i;
    assign eff_b = addr32_i ? {{HI_W{1'b0}}, addr_b_i[NARROW_W-1:0]} : addr_b_i;
    assign same_blk = (eff_a[ADDR_W-1:OFF_W] == eff_b[ADDR_W-1:OFF_W]);

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        edge_lane_masks #(.LANES(MASK_W >> g)) u_lanes (
            .off_a   (eff_a[OFF_W-1:0]),
            .off_b   (eff_b[OFF_W-1:0]),
            .little  (dec.little),
            .left_m  (left_arr[g]),
            .right_m (right_arr[g])
        );
    end

    always_comb begin
        left_sel  = left_arr[0];
        right_sel = right_arr[0];
        for (int s = 1; s < N_SIZES; s++) begin
            if (int'(dec.size) == s) begin
                left_sel  = left_arr[s];
                right_sel = right_arr[s];
            end
        end
        mask_n = same_blk ? (left_sel & right_sel) : left_sel;
    end

    edge_cc_calc #(.W(NARROW_W)) u_cc_lo (
        .a  (addr_a_i[NARROW_W-1:0]),
        .b  (addr_b_i[NARROW_W-1:0]),
        .cc (cc_lo_n)
    );

    edge_cc_calc #(.W(ADDR_W)) u_cc_hi (
        .a  (addr_a_i),
        .b  (addr_b_i),
        .cc (cc_hi_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            bad_q   <= 1'b0;
            we_q    <= 1'b0;
            mask_q  <= '0;
            cc_lo_q <= '0;
            cc_hi_q <= '0;
        end else begin
            done_q <= start_i;
            bad_q  <= start_i & ~dec.legal;
            we_q   <= start_i & dec.legal & ~dec.no_flags;
            if (start_i && dec.legal) begin
                mask_q <= mask_n;
                if (!dec.no_flags) begin
                    cc_lo_q <= cc_lo_n;
                    cc_hi_q <= cc_hi_n;
                end
            end
        end
    end

    assign done_o      = done_q;
    assign bad_op_o    = bad_q;
    assign cc_we_o     = we_q;
    assign lane_mask_o = mask_q;
    assign cc32_o      = cc_lo_q;
    assign cc64_o      = cc_hi_q;

    // ---------------- assertions ----------------
    p_done_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);

    p_we_for_flag_codes_r2: assert property (@(posedge clk) disable iff (rst)
        start_i && (opcode_i <= LAST_CODE) && !opcode_i[0] |=> cc_we_o);

    p_flags_kept_r10: assert property (@(posedge clk) disable iff (rst)
        start_i && (opcode_i <= LAST_CODE) && opcode_i[0]
        |=> !cc_we_o && $stable(cc32_o) && $stable(cc64_o));

    p_bad_code_holds_r11: assert property (@(posedge clk) disable iff (rst)
        start_i && (opcode_i > LAST_CODE)
        |=> bad_op_o && !cc_we_o && $stable(lane_mask_o) && $stable(cc64_o));

    p_half_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
        start_i && (opcode_i <= LAST_CODE) && (opcode_i[3:2] == 2'd1)
        |=> lane_mask_o[MASK_W-1:MASK_W/2] == '0);

    p_word_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
        start_i && (opcode_i <= LAST_CODE) && (opcode_i[3:2] == 2'd2)
        |=> lane_mask_o[MASK_W-1:MASK_W/4] == '0);

    p_zero_no_borrow_r9: assert property (@(posedge clk) disable iff (rst)
        cc_we_o && cc64_o[2] |-> !cc64_o[0] && !cc64_o[1] && !cc64_o[3]);

    p_bad_implies_done_r11: assert property (@(posedge clk) disable iff (rst)
        bad_op_o |-> done_o && !cc_we_o);

endmodule

// File: tb/edge_mask_unit_tb.sv
module edge_mask_unit_tb;

    typedef struct {
        logic        legal;
        logic        we;
        logic [7:0]  mask;
        logic [3:0]  f32;
        logic [3:0]  f64;
        int          lanes;
        string       mtag;
        string       ftag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [8:0]  opcode_i = '0;
    logic [63:0] addr_a_i = '0;
    logic [63:0] addr_b_i = '0;
    logic        addr32_i = 1'b0;
    logic        done_o, bad_op_o, cc_we_o;
    logic [7:0]  lane_mask_o;
    logic [3:0]  cc32_o, cc64_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    exp_item_t sb_q[$];
    exp_item_t cur;
    logic [7:0] m_mask = '0;
    logic [3:0] m_f32  = '0;
    logic [3:0] m_f64  = '0;

    always #10 clk = ~clk;

    edge_mask_unit u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
        .addr_a_i(addr_a_i), .addr_b_i(addr_b_i), .addr32_i(addr32_i),
        .done_o(done_o), .bad_op_o(bad_op_o), .cc_we_o(cc_we_o),
        .lane_mask_o(lane_mask_o), .cc32_o(cc32_o), .cc64_o(cc64_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Independent model: element j covered from left if j>=ia, from right if j<=ib
    function automatic logic [7:0] model_mask(logic [8:0] op, logic [63:0] a,
                                              logic [63:0] b, logic narrow);
        logic [63:0] ea, eb;
        logic [7:0]  l, r;
        int sz, lanes, ia, ib, elem;
        ea = narrow ? {32'd0, a[31:0]} : a;
        eb = narrow ? {32'd0, b[31:0]} : b;
        sz = int'(op[3:2]);
        lanes = 8 >> sz;
        ia = int'(ea[2:0]) >> sz;
        ib = int'(eb[2:0]) >> sz;
        l = '0; r = '0;
        for (int i = 0; i < lanes; i++) begin
            elem = op[1] ? i : (lanes - 1 - i);
            l[i] = (elem >= ia);
            r[i] = (elem <= ib);
        end
        return (ea[63:3] == eb[63:3]) ? (l & r) : l;
    endfunction

    function automatic logic [3:0] model_cc(logic [63:0] a, logic [63:0] b, int w);
        logic [64:0] d;
        logic sa, sb, sd, zz;
        if (w == 32) begin
            d = {33'd0, a[31:0]} - {33'd0, b[31:0]};
            sa = a[31]; sb = b[31]; sd = d[31]; zz = (d[31:0] == 0);
            return {sd, zz, (sa != sb) && (sd != sa), d[32]};
        end
        d = {1'b0, a} - {1'b0, b};
        sa = a[63]; sb = b[63]; sd = d[63]; zz = (d[63:0] == 0);
        return {sd, zz, (sa != sb) && (sd != sa), d[64]};
    endfunction

    // driver: one start per call, back-to-back when called repeatedly
    task automatic issue(input logic [8:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic narrow, input string tag);
        exp_item_t it;
        @(negedge clk);
        start_i = 1'b1; opcode_i = op; addr_a_i = a; addr_b_i = b; addr32_i = narrow;
        it.legal = (op <= 9'h00B);
        it.we    = it.legal && !op[0];
        it.lanes = it.legal ? (8 >> int'(op[3:2])) : 8;
        if (it.legal) begin
            m_mask = model_mask(op, a, b, narrow);
            if (!op[0]) begin
                m_f32 = model_cc(a, b, 32);
                m_f64 = model_cc(a, b, 64);
            end
        end
        it.mask = m_mask; it.f32 = m_f32; it.f64 = m_f64;
        if (!it.legal) begin
            it.mtag = "R11"; it.ftag = "R11";
        end else begin
            it.mtag = tag;
            it.ftag = op[0] ? "R10" : "R9";
        end
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    function automatic string size_tag(logic [8:0] op);
        case (op[3:2])
            2'd0: return op[1] ? "R6" : "R3";
            2'd1: return "R4";
            default: return "R5";
        endcase
    endfunction

    // monitor
    always @(negedge clk) begin
        if (!rst) cycles++;
        if (!rst && done_o) begin
            if (sb_q.size() == 0) begin
                check("R1 done without start", 64'd1, 64'd0);
            end else begin
                cur = sb_q.pop_front();
                check("R11 bad_op", {63'd0, bad_op_o}, {63'd0, !cur.legal});
                check("R2 cc_we", {63'd0, cc_we_o}, {63'd0, cur.we});
                check({cur.mtag, " mask"}, {56'd0, lane_mask_o}, {56'd0, cur.mask});
                check({cur.ftag, " cc32"}, {60'd0, cc32_o}, {60'd0, cur.f32});
                check({cur.ftag, " cc64"}, {60'd0, cc64_o}, {60'd0, cur.f64});
                check("R12 upper lanes", {56'd0, lane_mask_o >> cur.lanes}, 64'd0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog expired act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset done", {63'd0, done_o}, 64'd0);
        check("R1 reset mask", {56'd0, lane_mask_o}, 64'd0);
        check("R1 reset cc", {56'd0, cc32_o, cc64_o}, 64'd0);
        check("R1 reset flags", {62'd0, bad_op_o, cc_we_o}, 64'd0);

        // full offset sweep in one block and across blocks (R3-R7)
        for (int op = 0; op < 12; op++) begin
            for (int oa = 0; oa < 8; oa++) begin
                for (int ob = 0; ob < 8; ob++) begin
                    issue(9'(op), 64'h0000_1234_5678_9A00 + 64'(oa),
                          64'h0000_1234_5678_9A00 + 64'(ob), 1'b0, size_tag(9'(op)));
                end
                issue(9'(op), 64'h0000_1234_5678_9A00 + 64'(oa),
                      64'h0000_1234_5678_9A18 + 64'(oa), 1'b0, "R7");
            end
        end
        idle(2);

        // narrow mode: upper halves differ (R8), flags use full values (R9)
        issue(9'h000, 64'hFFFF_0000_0000_0013, 64'h0000_0001_0000_0015, 1'b1, "R8");
        issue(9'h000, 64'hFFFF_0000_0000_0013, 64'h0000_0001_0000_0015, 1'b0, "R8");
        issue(9'h006, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0004, 1'b1, "R8");
        issue(9'h008, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0000, 1'b1, "R8");
        issue(9'h00A, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0, "R5");
        issue(9'h004, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 1'b0, "R4");
        issue(9'h002, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005, 1'b0, "R6");
        idle(1);

        // illegal codes keep state (R11), no-flag codes hold flags (R10)
        issue(9'h00C, 64'h7, 64'h0, 1'b0, "R11");
        issue(9'h1FF, 64'h3, 64'h9, 1'b0, "R11");
        issue(9'h001, 64'h2, 64'hF, 1'b0, "R3");
        issue(9'h010, 64'h1, 64'h1, 1'b1, "R11");
        idle(3);

        // random mix with back-to-back starts
        for (int k = 0; k < 400; k++) begin
            logic [8:0] rop;
            logic [63:0] ra, rb;
            rop = ($urandom_range(0, 9) == 0) ? 9'($urandom_range(12, 511))
                                              : 9'($urandom_range(0, 11));
            ra = {$urandom, $urandom};
            rb = ($urandom_range(0, 1) == 1) ? {ra[63:3], 3'($urandom)} : {$urandom, $urandom};
            issue(rop, ra, rb, 1'($urandom), size_tag(rop));
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(4);

        check("R1 all results seen", 64'(sb_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule